// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block is one DMA channel whose transfer setup comes from a 16-byte descriptor held in memory instead of from its own registers. Software sets a descriptor base address and a writeback base address while the controller is globally disabled, turns on the global enable, and then sets the channel enable bit. The channel reads the four descriptor words over its memory bus and checks the valid bit. It then waits for a peripheral trigger before each beat. A beat is one read from the source address followed by one write to the destination address.

The address fields in the descriptor point one byte past the end of each buffer. The channel works out the start address from the beat count, the beat size and an optional power-of-two step on one side. Either side can stay fixed, which suits a peripheral data register. When the last beat finishes, the channel writes a 16-byte progress record to the writeback area, sets a transfer-complete flag, raises its interrupt if that is enabled, and clears its own enable bit.

Top module: `dmaChannel`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `memReq` is low. The register word index (`regAddr`) maps as follows: 0 = global enable in bit 0; 1 = descriptor base; 2 = writeback base; 3 = channel control (bit 0 enable, bits 2:1 beat size); 4 = interrupt enable in bit 0; 5 = transfer-complete flag in bit 0.
- R2: The two base registers take a write only while the global enable is 0. Their low 4 bits always read as 0.
- R3: With the global enable at 1, setting the channel enable makes the channel read four 32-bit words from base+0, +4, +8 and +12. Word 0 holds the control word in [15:0] and the beat count in [31:16]. Words 1 to 3 hold the source end address, the destination end address and the next-descriptor address.
- R4: If control bit 0 (valid) is 0, the channel makes no beats, clears its enable bit and leaves the flag at 0.
- R5: Control bit 10 enables source increment and bit 11 enables destination increment. An incrementing side starts at its field minus count × beat bytes and advances by the beat bytes on each beat. A fixed side uses its field on every beat.
- R6: Bits 15:13 give a step exponent k. On the side picked by bit 12 (1 = source, 0 = destination), both the start offset and the per-beat advance are multiplied by 2^k.
- R7: A beat size code of 0, 1 or 2 moves 8, 16 or 32 bits per beat. The code appears on `memSize` for beat accesses. Descriptor and writeback accesses always use code 2.
- R8: Each trigger moves exactly one beat. A trigger that arrives while a beat is in progress is held as a single pending request: several such triggers still add only one beat.
- R9: After the last beat the channel writes four words to the writeback base: {remaining count = 0, control word}, the current source address, the current destination address and the next-descriptor field. It then sets the flag, clears its enable bit and drives `irq` high if the interrupt enable is 1.
- R10: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.
- R11: Writing 0 to the channel enable during a transfer lets the current beat finish and then stops. No writeback is made, the flag is not set, and later triggers have no effect.
- R12: Once `memReq` is raised, it stays high and `memAddr` and `memWe` stay constant until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| trigger | input | 1 | Peripheral beat request |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memSize | output | 2 | Access size code (0 = byte, 1 = half, 2 = word) |
| memAddr | output | ADDR_W | Byte address |
| memWdata | output | 32 | Write data, low-aligned |
| memRdata | input | 32 | Read data, low-aligned |
| memAck | input | 1 | Access complete |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
The main copy path is run with four descriptor shapes, and each one separates a different part of the address arithmetic. Byte beats with both sides incrementing check the end-address-to-start conversion and the writeback record. Halfword beats into a fixed destination show that the fixed side never moves, because only the last value survives there. Word beats with a doubled source step show whether the step lands on the correct side, because the skipped source words must never reach the destination. Trigger bursts of two and three cycles tell a single pending latch apart from a design that drops triggers or counts each one.

// File: rtl/dmaPkg.sv
package dmaPkg;
  localparam int CNT_W       = 16;
  localparam int WORD_W      = 32;
  localparam int DESC_WORDS  = 4;
  localparam int VALID_BIT   = 0;
  localparam int SRCINC_BIT  = 10;
  localparam int DSTINC_BIT  = 11;
  localparam int STEPSEL_BIT = 12;
  localparam int STEP_LSB    = 13;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_WAIT, S_READ, S_WRITE, S_WBACK
  } dmaState_t;

  typedef enum logic [1:0] {BUS_DESC, BUS_SRC, BUS_DST, BUS_WB} busSel_t;

  typedef struct packed {
    logic     loadWord;
    logic     startXfer;
    logic     captureData;
    logic     advance;
    busSel_t  busSel;
    logic [1:0] wordIdx;
  } dmaStrobe_t;
endpackage

// File: rtl/dmaRegs.sv
module dmaRegs #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              clrEnable,
  input  logic              setFlag,
  output logic              globalEn,
  output logic              chEnable,
  output logic [1:0]        beatSize,
  output logic [ADDR_W-1:0] descBase,
  output logic [ADDR_W-1:0] wbBase,
  output logic              flagTc,
  output logic              irq
);
  logic intEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      chEnable <= 1'b0;
      beatSize <= 2'd0;
      descBase <= '0;
      wbBase   <= '0;
      intEn    <= 1'b0;
      flagTc   <= 1'b0;
    end else begin
      if (regWr) begin
        case (regAddr)
          3'd0: globalEn <= regWdata[0];
          3'd1: if (!globalEn) descBase <= {regWdata[ADDR_W-1:4], 4'b0};
          3'd2: if (!globalEn) wbBase <= {regWdata[ADDR_W-1:4], 4'b0};
          3'd3: begin
            chEnable <= regWdata[0];
            beatSize <= regWdata[2:1];
          end
          3'd4: intEn <= regWdata[0];
          3'd5: if (regWdata[0]) flagTc <= 1'b0;
          default: ;
        endcase
      end
      if (clrEnable) chEnable <= 1'b0;
      if (setFlag) flagTc <= 1'b1;
    end
  end

  always_comb begin
    case (regAddr)
      3'd0: regRdata = {31'b0, globalEn};
      3'd1: regRdata = 32'(descBase);
      3'd2: regRdata = 32'(wbBase);
      3'd3: regRdata = {29'b0, beatSize, chEnable};
      3'd4: regRdata = {31'b0, intEn};
      3'd5: regRdata = {31'b0, flagTc};
      default: regRdata = '0;
    endcase
  end

  assign irq = flagTc & intEn;
endmodule

// File: rtl/dmaCtrl.sv
module dmaCtrl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       globalEn,
  input  logic       chEnable,
  input  logic       trigger,
  input  logic       memAck,
  input  logic       descValid,
  input  logic       cntZero,
  input  logic       cntOne,
  output dmaStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       clrEnable,
  output logic       setFlag,
  output dmaState_t  ctrlState,
  output logic       pending
);
  localparam logic [1:0] LAST_IDX = 2'(DESC_WORDS - 1);

  dmaState_t  nextState;
  logic [1:0] wordIdx, nextIdx;
  logic       consume;

  always_comb begin
    strobe         = '0;
    strobe.wordIdx = wordIdx;
    strobe.busSel  = BUS_DESC;
    memReq    = 1'b0;
    memWe     = 1'b0;
    clrEnable = 1'b0;
    setFlag   = 1'b0;
    consume   = 1'b0;
    nextState = ctrlState;
    nextIdx   = wordIdx;
    case (ctrlState)
      S_IDLE: if (globalEn && chEnable) begin
        nextState = S_FETCH;
        nextIdx   = '0;
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.loadWord = 1'b1;
          if (wordIdx == LAST_IDX) nextState = S_CHECK;
          else nextIdx = wordIdx + 2'd1;
        end
      end
      S_CHECK: begin
        if (!descValid) begin
          clrEnable = 1'b1;
          nextState = S_IDLE;
        end else begin
          strobe.startXfer = 1'b1;
          nextIdx   = '0;
          nextState = cntZero ? S_WBACK : S_WAIT;
        end
      end
      S_WAIT: begin
        if (!chEnable) nextState = S_IDLE;
        else if (trigger || pending) begin
          consume   = 1'b1;
          nextState = S_READ;
        end
      end
      S_READ: begin
        memReq = 1'b1;
        strobe.busSel = BUS_SRC;
        if (memAck) begin
          strobe.captureData = 1'b1;
          nextState = S_WRITE;
        end
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.busSel = BUS_DST;
        if (memAck) begin
          strobe.advance = 1'b1;
          nextIdx = '0;
          if (cntOne) nextState = S_WBACK;
          else if (!chEnable) nextState = S_IDLE;
          else nextState = S_WAIT;
        end
      end
      S_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        strobe.busSel = BUS_WB;
        if (memAck) begin
          if (wordIdx == LAST_IDX) begin
            setFlag   = 1'b1;
            clrEnable = 1'b1;
            nextState = S_IDLE;
          end else nextIdx = wordIdx + 2'd1;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlState <= S_IDLE;
      wordIdx   <= '0;
      pending   <= 1'b0;
    end else begin
      ctrlState <= nextState;
      wordIdx   <= nextIdx;
      if (ctrlState == S_IDLE) pending <= 1'b0;
      else if (consume) pending <= pending & trigger;
      else if (trigger) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [31:0]       memRdata,
  input  logic [1:0]        beatSize,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [ADDR_W-1:0] wbBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [1:0]        memSize,
  output logic              descValid,
  output logic              cntZero,
  output logic              cntOne
);
  localparam int SIDES = 2;

  logic [15:0]       ctrlWord;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] nextDesc;
  logic [31:0]       beatData;
  logic [1:0]        beatShift;
  logic [ADDR_W-1:0] sideAddr [SIDES];
  logic [ADDR_W-1:0] wordOffset;

  assign beatShift  = (beatSize == 2'd0) ? 2'd0 : (beatSize == 2'd1) ? 2'd1 : 2'd2;
  assign wordOffset = ADDR_W'({strobe.wordIdx, 2'b00});

  genvar s;
  generate
    for (s = 0; s < SIDES; s++) begin : g_side
      localparam int   INC_BIT    = (s == 0) ? SRCINC_BIT : DSTINC_BIT;
      localparam logic STEP_MATCH = (s == 0) ? 1'b1 : 1'b0;
      localparam logic [1:0] FIELD_IDX = 2'(s + 1);
      logic [ADDR_W-1:0] addrQ;
      logic [3:0]        shiftAmt;
      assign shiftAmt = {2'b0, beatShift} +
        ((ctrlWord[STEPSEL_BIT] == STEP_MATCH) ? {1'b0, ctrlWord[STEP_LSB+:3]} : 4'd0);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) addrQ <= '0;
        else if (strobe.loadWord && strobe.wordIdx == FIELD_IDX) addrQ <= ADDR_W'(memRdata);
        else if (strobe.startXfer && ctrlWord[INC_BIT])
          addrQ <= addrQ - (ADDR_W'(count) << shiftAmt);
        else if (strobe.advance && ctrlWord[INC_BIT])
          addrQ <= addrQ + (ADDR_W'(1) << shiftAmt);
      end
      assign sideAddr[s] = addrQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      count    <= '0;
      nextDesc <= '0;
      beatData <= '0;
    end else begin
      if (strobe.loadWord && strobe.wordIdx == 2'd0) begin
        ctrlWord <= memRdata[15:0];
        count    <= memRdata[31:16];
      end
      if (strobe.loadWord && strobe.wordIdx == 2'd3) nextDesc <= ADDR_W'(memRdata);
      if (strobe.captureData) beatData <= memRdata;
      if (strobe.advance) count <= count - 1'b1;
    end
  end

  assign descValid = ctrlWord[VALID_BIT];
  assign cntZero   = (count == '0);
  assign cntOne    = (count == CNT_W'(1));

  always_comb begin
    memSize = 2'd2;
    case (strobe.busSel)
      BUS_DESC: memAddr = descBase + wordOffset;
      BUS_SRC: begin memAddr = sideAddr[0]; memSize = beatShift; end
      BUS_DST: begin memAddr = sideAddr[1]; memSize = beatShift; end
      default: memAddr = wbBase + wordOffset;
    endcase
    case (strobe.wordIdx)
      2'd0: memWdata = {count, ctrlWord};
      2'd1: memWdata = 32'(sideAddr[0]);
      2'd2: memWdata = 32'(sideAddr[1]);
      default: memWdata = 32'(nextDesc);
    endcase
    if (strobe.busSel == BUS_DST) memWdata = beatData;
  end
endmodule

// File: rtl/dmaChannel.sv
module dmaChannel
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              trigger,
  output logic              memReq,
  output logic              memWe,
  output logic [1:0]        memSize,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              irq
);
  dmaStrobe_t        strobe;
  dmaState_t         ctrlState;
  logic              globalEn, chEnable, flagTc, pending;
  logic              clrEnable, setFlag, descValid, cntZero, cntOne;
  logic [1:0]        beatSize;
  logic [ADDR_W-1:0] descBase, wbBase;

  dmaRegs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .clrEnable(clrEnable),
    .setFlag(setFlag), .globalEn(globalEn), .chEnable(chEnable),
    .beatSize(beatSize), .descBase(descBase), .wbBase(wbBase),
    .flagTc(flagTc), .irq(irq)
  );

  dmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .chEnable(chEnable),
    .trigger(trigger), .memAck(memAck), .descValid(descValid),
    .cntZero(cntZero), .cntOne(cntOne), .strobe(strobe), .memReq(memReq),
    .memWe(memWe), .clrEnable(clrEnable), .setFlag(setFlag),
    .ctrlState(ctrlState), .pending(pending)
  );

  dmaDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdata(memRdata),
    .beatSize(beatSize), .descBase(descBase), .wbBase(wbBase),
    .memAddr(memAddr), .memWdata(memWdata), .memSize(memSize),
    .descValid(descValid), .cntZero(cntZero), .cntOne(cntOne)
  );
endmodule

// File: rtl/dmaChannelChecker.sv
module dmaChannelChecker
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              trigger,
  input logic              globalEn,
  input logic              chEnable,
  input logic              flagTc,
  input logic              pending,
  input logic [ADDR_W-1:0] descBase,
  input dmaState_t         ctrlState
);
  a_r12_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  a_r2_base_locked: assert property (@(posedge clk) disable iff (!rstN)
    globalEn |=> $stable(descBase));

  a_r9_flag_drops_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagTc) |-> !chEnable);

  a_r8_beat_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_READ && $past(ctrlState) == S_WAIT) |-> $past(trigger || pending));

  a_r3_fetch_in_descriptor: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_FETCH && memReq) |->
      (memAddr[ADDR_W-1:4] == descBase[ADDR_W-1:4]) && (memAddr[1:0] == 2'b00) && !memWe);

  a_r11_stop_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_WAIT && !chEnable) |=> ctrlState == S_IDLE);
endmodule

bind dmaChannel dmaChannelChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memWe(memWe),
  .memAddr(memAddr), .trigger(trigger), .globalEn(globalEn),
  .chEnable(chEnable), .flagTc(flagTc), .pending(pending),
  .descBase(descBase), .ctrlState(ctrlState)
);

// File: tb/dmaChannel_test.sv
module dmaChannel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        trigger = 1'b0;
  logic        memReq, memWe, irq;
  logic [1:0]  memSize;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memAck = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  int dstWrites = 0;
  int holdErrs = 0;
  logic        logArm = 1'b0;
  logic [31:0] firstRd = '0;
  logic [31:0] ackAddr = '0;
  bit          done = 0;

  logic [7:0] mem [0:255];

  always #4 clk = ~clk;

  dmaChannel uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .trigger(trigger),
    .memReq(memReq), .memWe(memWe), .memSize(memSize), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .irq(irq)
  );

  // memory model: acknowledges one cycle after a request is seen
  always @(posedge clk) begin
    if (memAck && memAddr !== ackAddr) holdErrs++;
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      logic [31:0] rd;
      rd = '0;
      ackAddr = memAddr;
      for (int b = 0; b < (1 << memSize); b++) begin
        if (memWe) mem[8'(memAddr + b)] = memWdata[8*b +: 8];
        rd[8*b +: 8] = mem[8'(memAddr + b)];
      end
      if (memWe && memAddr[7:0] >= 8'h80) dstWrites++;
      if (!memWe && logArm) begin
        firstRd = memAddr;
        logArm = 1'b0;
      end
      memAck   <= 1'b1;
      memRdata <= rd;
    end
  end

  function automatic logic [31:0] mem32(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic put32(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic trig(input int len);
    @(negedge clk);
    trigger = 1'b1;
    repeat (len) @(negedge clk);
    trigger = 1'b0;
    idle(8);
  endtask

  // descriptor at 0x10, writeback at 0x20
  task automatic setDesc(input logic [15:0] ctl, input logic [15:0] cnt,
                         input logic [31:0] srcEnd, input logic [31:0] dstEnd);
    put32(16'h10, {cnt, ctl});
    put32(16'h14, srcEnd);
    put32(16'h18, dstEnd);
    put32(16'h1C, 32'h0000_00C0);
    for (int a = 16'h80; a < 16'hC0; a++) mem[a] = 8'h00;
    for (int a = 16'h20; a < 16'h30; a++) mem[a] = 8'hFF;
    dstWrites = 0;
  endtask

  task automatic startCh(input logic [1:0] size);
    logArm = 1'b1;
    regWrite(3'd3, {29'b0, size, 1'b1});
    idle(14);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      regRead(3'(a), v);
      chk("R1 register reset value", v, 32'h0);
    end
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    chk("R1 memReq at reset", {31'b0, memReq}, 32'h0);
  endtask

  task automatic t_baseLock;
    logic [31:0] v;
    regWrite(3'd1, 32'h0000_0013);
    regWrite(3'd2, 32'h0000_002F);
    regRead(3'd1, v); chk("R2 base low bits dropped", v, 32'h10);
    regRead(3'd2, v); chk("R2 writeback low bits dropped", v, 32'h20);
    regWrite(3'd0, 32'h1);
    regWrite(3'd1, 32'h0000_0070);
    regRead(3'd1, v); chk("R2 base locked while enabled", v, 32'h10);
    regWrite(3'd4, 32'h1);
  endtask

  task automatic t_basicCopy;
    logic [31:0] v;
    setDesc(16'h0C01, 16'd4, 32'h44, 32'h84);
    put32(16'h40, 32'h4433_2211);
    startCh(2'd0);
    chk("R3 first fetch at descriptor base", firstRd, 32'h10);
    for (int i = 0; i < 3; i++) trig(1);
    regRead(3'd5, v); chk("R8 no flag before last beat", v, 32'h0);
    chk("R8 three beats for three triggers", dstWrites, 32'd3);
    trig(1);
    idle(12);
    chk("R5 incrementing copy data", mem32(16'h80), 32'h4433_2211);
    chk("R9 writeback word0", mem32(16'h20), 32'h0000_0C01);
    chk("R9 writeback source", mem32(16'h24), 32'h44);
    chk("R9 writeback destination", mem32(16'h28), 32'h84);
    chk("R9 writeback next field", mem32(16'h2C), 32'hC0);
    regRead(3'd5, v); chk("R9 flag set", v, 32'h1);
    regRead(3'd3, v); chk("R9 enable cleared", {31'b0, v[0]}, 32'h0);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_flagClear;
    logic [31:0] v;
    regWrite(3'd5, 32'h0);
    regRead(3'd5, v); chk("R10 writing 0 keeps flag", v, 32'h1);
    regWrite(3'd5, 32'h1);
    regRead(3'd5, v); chk("R10 writing 1 clears flag", v, 32'h0);
    chk("R10 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fixedDst;
    setDesc(16'h0401, 16'd3, 32'h46, 32'hA0);
    put32(16'h40, 32'h2222_1111);
    put32(16'h44, 32'h0000_3333);
    startCh(2'd1);
    for (int i = 0; i < 3; i++) trig(1);
    idle(12);
    chk("R5 fixed destination holds last halfword", mem32(16'hA0), 32'h0000_3333);
    chk("R7 halfword beats written", dstWrites, 32'd3);
    chk("R5 fixed destination writeback", mem32(16'h28), 32'hA0);
    regWrite(3'd5, 32'h1);
  endtask

  task automatic t_step;
    setDesc(16'h3C01, 16'd2, 32'h60, 32'h90);
    put32(16'h50, 32'hA5A5_0001);
    put32(16'h54, 32'hDEAD_BEEF);
    put32(16'h58, 32'hA5A5_0002);
    startCh(2'd2);
    trig(1);
    trig(1);
    idle(12);
    chk("R6 stepped source first word", mem32(16'h88), 32'hA5A5_0001);
    chk("R6 stepped source skips word", mem32(16'h8C), 32'hA5A5_0002);
    chk("R6 source end after steps", mem32(16'h24), 32'h60);
    regWrite(3'd5, 32'h1);
  endtask

  task automatic t_invalid;
    logic [31:0] v;
    setDesc(16'h0C00, 16'd2, 32'h44, 32'h84);
    startCh(2'd0);
    trig(1);
    trig(1);
    chk("R4 no beats from invalid descriptor", dstWrites, 32'd0);
    regRead(3'd3, v); chk("R4 enable cleared", {31'b0, v[0]}, 32'h0);
    regRead(3'd5, v); chk("R4 flag not set", v, 32'h0);
  endtask

  task automatic t_pending;
    logic [31:0] v;
    setDesc(16'h0C01, 16'd5, 32'h45, 32'h85);
    startCh(2'd0);
    trig(2);
    idle(6);
    chk("R8 two-cycle burst gives two beats", dstWrites, 32'd2);
    trig(3);
    idle(6);
    chk("R8 three-cycle burst gives two beats", dstWrites, 32'd4);
    regRead(3'd5, v); chk("R8 not complete yet", v, 32'h0);
    trig(1);
    idle(12);
    regRead(3'd5, v); chk("R8 complete after fifth beat", v, 32'h1);
    regWrite(3'd5, 32'h1);
  endtask

  task automatic t_stop;
    logic [31:0] v;
    setDesc(16'h0C01, 16'd4, 32'h44, 32'h84);
    startCh(2'd0);
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    regWr = 1'b1; regAddr = 3'd3; regWdata = 32'h0;
    @(negedge clk);
    regWr = 1'b0;
    idle(10);
    chk("R11 current beat finishes", dstWrites, 32'd1);
    trig(1);
    trig(1);
    chk("R11 triggers ignored after stop", dstWrites, 32'd1);
    regRead(3'd5, v); chk("R11 flag not set", v, 32'h0);
    chk("R11 no writeback", mem32(16'h20), 32'hFFFF_FFFF);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    idle(3);
    rstN = 1'b1;
    idle(2);
    t_reset();
    t_baseLock();
    t_basicCopy();
    t_flagClear();
    t_fixedDst();
    t_step();
    t_invalid();
    t_pending();
    t_stop();
    chk("R12 address held until acknowledge", holdErrs, 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule